// File: doc/BRIEF.md
# Multiprocessor Wake Sequencer

This block sits beside the bootstrap core and brings the other cores of a multiprocessor out of reset. A single start pulse launches a fixed three-command sequence toward an inter-processor interrupt sender. The first command is a reset-style INIT request. A long pause follows, then a startup request, then a short pause, then a second startup request. The second startup request is redundant by design: a core that the first one already woke ignores it. Every command is addressed with the "all but the requesting core" shorthand, so no destination ID is ever driven.

Each command is offered on a valid/ready port and held steady until the sender accepts it. A pause only begins once the preceding command has been accepted. Pauses are counted in microseconds. An internal prescaler divides the clock by a parameter to make a one-microsecond tick. The 8-bit startup vector sets the page the woken cores start from (08h selects 08000h). It is taken from an input at the moment the sequence starts. While the sequence runs `busy_o` is high, and `done_o` pulses once at the end.

Top module: `mp_wake_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `busy_o`, `done_o` and `cmd_valid_o` are all low.
- R2: With `busy_o` low, a high `start_i` at a clock edge makes `busy_o` and `cmd_valid_o` high on the next cycle, with `cmd_type_o` = 2'b01 (INIT) and `cmd_vector_o` = 0.
- R3: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_type_o` and `cmd_vector_o` stay unchanged on the next cycle.
- R4: After the INIT command is accepted, `cmd_valid_o` stays low for exactly INIT_WAIT_US × CYC_PER_US cycles before the first startup command appears.
- R5: Both startup commands carry in `cmd_vector_o` the value `vector_i` had at the accepted start; later changes of `vector_i` have no effect.
- R6: After the first startup command is accepted, `cmd_valid_o` stays low for exactly SIPI_WAIT_US × CYC_PER_US cycles before the second startup command appears.
- R7: Every offered command has `cmd_shorthand_o` = 2'b11 (all cores except the sender).
- R8: On the cycle after the second startup command is accepted, `done_o` is high for exactly one cycle, `busy_o` is low, and `cmd_valid_o` is low.
- R9: `start_i` has no effect while `busy_o` is high: pause lengths, command order and vectors are unchanged, and no new command appears after `done_o`.
- R10: One sequence offers exactly three commands, in the order INIT (2'b01), startup (2'b10), startup (2'b10).
- R11: Accepting a command drops `cmd_valid_o` on the next cycle, and the following pause is timed from that acceptance no matter how long `cmd_ready_i` was held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a sequence when idle |
| vector_i | input | 8 | Startup vector, captured at start |
| cmd_valid_o | output | 1 | A command is offered |
| cmd_ready_i | input | 1 | Sender accepts the offered command |
| cmd_type_o | output | 2 | 01 INIT, 10 startup, 00 none |
| cmd_vector_o | output | 8 | Vector of the offered command |
| cmd_shorthand_o | output | 2 | Destination shorthand, 11 = all except self |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The first command is due one cycle after start is sampled. Each later command is due exactly the pause length in cycles after the previous command is accepted. `done_o` rises the cycle after the last acceptance. The bench drives inputs and samples outputs only on falling edges. It counts the falling edges on which `cmd_valid_o` is low between an acceptance and the next command, and compares that count with the parameter product. Ready latency, vector changes and spurious starts are randomized inside those windows, so every timing check runs against varying surroundings.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_INIT  = 2'b01,
    CMD_START = 2'b10
  } cmd_e;

  localparam logic [1:0] SH_ALL_BUT_SELF = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_INIT   = 3'd1,
    S_WLONG  = 3'd2,
    S_SIPI1  = 3'd3,
    S_WSHORT = 3'd4,
    S_SIPI2  = 3'd5
  } state_e;

endpackage

// File: rtl/mp_wake_us_tick.sv
module mp_wake_us_tick #(
  parameter int unsigned CYC_PER_US = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CYC_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (!run_i)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == LAST);

      a_r4_pre_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_q == '0))
        else $error("prescaler not cleared outside a pause");
    end
  endgenerate

endmodule

// File: rtl/mp_wake_delay.sv
module mp_wake_delay #(
  parameter int unsigned LONG_US  = 10000,
  parameter int unsigned SHORT_US = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int unsigned MAX_US = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int unsigned CW     = $clog2(MAX_US + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_US - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_US - 1);

  logic [CW-1:0] us_q;
  logic [CW-1:0] last;

  assign last     = long_i ? LONG_LAST : SHORT_LAST;
  assign expire_o = run_i && tick_i && (us_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       us_q <= '0;
    else if (!run_i)   us_q <= '0;
    else if (tick_i)   us_q <= (us_q == last) ? '0 : us_q + 1'b1;
  end

  a_r4_us_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (us_q <= last))
    else $error("microsecond count beyond pause length");

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (!run_i || $stable(us_q)))
    else $error("microsecond count moved without a tick");

endmodule

// File: rtl/mp_wake_fsm.sv
module mp_wake_fsm
  import mp_wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] vector_i,
  input  logic       cmd_ready_i,
  input  logic       expire_i,
  output logic       run_o,
  output logic       long_o,
  output logic       cmd_valid_o,
  output logic [1:0] cmd_type_o,
  output logic [7:0] cmd_vector_o,
  output logic       busy_o,
  output logic       done_o
);

  state_e     state_q, state_d;
  logic [7:0] vec_q;
  logic       done_q;
  logic       accept;

  assign accept = cmd_valid_o && cmd_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i)  state_d = S_INIT;
      S_INIT:   if (accept)   state_d = S_WLONG;
      S_WLONG:  if (expire_i) state_d = S_SIPI1;
      S_SIPI1:  if (accept)   state_d = S_WSHORT;
      S_WSHORT: if (expire_i) state_d = S_SIPI2;
      S_SIPI2:  if (accept)   state_d = S_IDLE;
      default:                state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_SIPI2) && accept;
      if (state_q == S_IDLE && start_i) vec_q <= vector_i;
    end
  end

  always_comb begin
    cmd_valid_o  = 1'b0;
    cmd_type_o   = CMD_NONE;
    cmd_vector_o = '0;
    unique case (state_q)
      S_INIT: begin
        cmd_valid_o = 1'b1;
        cmd_type_o  = CMD_INIT;
      end
      S_SIPI1, S_SIPI2: begin
        cmd_valid_o  = 1'b1;
        cmd_type_o   = CMD_START;
        cmd_vector_o = vec_q;
      end
      default: ;
    endcase
  end

  assign run_o  = (state_q == S_WLONG) || (state_q == S_WSHORT);
  assign long_o = (state_q == S_WLONG);
  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;

  a_r2_start_offers_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (cmd_valid_o && cmd_type_o == CMD_INIT && busy_o))
    else $error("start did not offer INIT");

  a_r3_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_type_o) && $stable(cmd_vector_o)))
    else $error("command changed before acceptance");

  a_r11_drop_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !cmd_valid_o)
    else $error("valid held after acceptance");

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !cmd_valid_o))
    else $error("done while busy");

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmd_valid_o && !expire_i) |=> !cmd_valid_o)
    else $error("command appeared mid pause");

  a_r10_init_then_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_type_o == CMD_INIT) |=> (run_o && long_o))
    else $error("INIT not followed by long pause");

endmodule

// File: rtl/mp_wake_seq.sv
module mp_wake_seq
  import mp_wake_pkg::*;
#(
  parameter int unsigned CYC_PER_US   = 200,
  parameter int unsigned INIT_WAIT_US = 10000,
  parameter int unsigned SIPI_WAIT_US = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] vector_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [1:0] cmd_type_o,
  output logic [7:0] cmd_vector_o,
  output logic [1:0] cmd_shorthand_o,
  output logic       busy_o,
  output logic       done_o
);

  logic run, long_sel, tick, expire;

  mp_wake_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  mp_wake_delay #(.LONG_US(INIT_WAIT_US), .SHORT_US(SIPI_WAIT_US)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .long_i  (long_sel),
    .tick_i  (tick),
    .expire_o(expire)
  );

  mp_wake_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .vector_i    (vector_i),
    .cmd_ready_i (cmd_ready_i),
    .expire_i    (expire),
    .run_o       (run),
    .long_o      (long_sel),
    .cmd_valid_o (cmd_valid_o),
    .cmd_type_o  (cmd_type_o),
    .cmd_vector_o(cmd_vector_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign cmd_shorthand_o = SH_ALL_BUT_SELF;

endmodule

// File: tb/mp_wake_seq_tb_top.sv
module mp_wake_seq_tb_top;

  localparam int CYC  = 4;
  localparam int LONG = 50;
  localparam int SHRT = 8;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [7:0] vector_i;
  logic       cmd_valid_o;
  logic       cmd_ready_i;
  logic [1:0] cmd_type_o;
  logic [7:0] cmd_vector_o;
  logic [1:0] cmd_shorthand_o;
  logic       busy_o;
  logic       done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mp_wake_seq #(.CYC_PER_US(CYC), .INIT_WAIT_US(LONG), .SIPI_WAIT_US(SHRT)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .vector_i       (vector_i),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_ready_i    (cmd_ready_i),
    .cmd_type_o     (cmd_type_o),
    .cmd_vector_o   (cmd_vector_o),
    .cmd_shorthand_o(cmd_shorthand_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  function automatic int exp_gap(int k);
    return (k == 0) ? LONG * CYC : SHRT * CYC;
  endfunction

  function automatic logic [1:0] exp_type(int k);
    return (k == 0) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [7:0] exp_vec(int k, logic [7:0] v);
    return (k == 0) ? 8'h00 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input logic [7:0] v, input int max_lat, input bit always_rdy,
                         input bit noise);
    int g;
    int lat;
    logic [1:0] t0;
    logic [7:0] v0;
    vector_i    = v;
    start_i     = 1'b1;
    cmd_ready_i = always_rdy;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
    for (int k = 0; k < 3; k++) begin
      chk(cmd_valid_o == 1'b1, "R2/R10 valid", cmd_valid_o, 1);
      chk(cmd_type_o == exp_type(k), "R10 type", cmd_type_o, exp_type(k));
      chk(cmd_vector_o == exp_vec(k, v), "R5 vector", cmd_vector_o, exp_vec(k, v));
      chk(cmd_shorthand_o == 2'b11, "R7 shorthand", cmd_shorthand_o, 3);
      t0 = cmd_type_o;
      v0 = cmd_vector_o;
      lat = always_rdy ? 0 : $urandom_range(max_lat, 0);
      for (int i = 0; i < lat; i++) begin
        if (noise) begin
          vector_i = 8'($urandom);
          start_i  = 1'($urandom);
        end
        @(negedge clk);
        chk(cmd_valid_o && cmd_type_o == t0 && cmd_vector_o == v0, "R3 hold",
            {cmd_valid_o, cmd_type_o, cmd_vector_o}, {1'b1, t0, v0});
      end
      cmd_ready_i = 1'b1;
      start_i     = 1'b0;
      @(negedge clk);
      if (!always_rdy) cmd_ready_i = 1'b0;
      if (k < 2) begin
        chk(cmd_valid_o == 1'b0, "R11 drop", cmd_valid_o, 0);
        g = 0;
        while (!cmd_valid_o && g < 100000) begin
          g++;
          if (noise) begin
            vector_i = 8'($urandom);
            start_i  = 1'($urandom);
          end
          @(negedge clk);
        end
        start_i = 1'b0;
        chk(g == exp_gap(k), (k == 0) ? "R4 long pause" : "R6 short pause", g, exp_gap(k));
      end else begin
        chk(done_o && !busy_o && !cmd_valid_o, "R8 done",
            {done_o, busy_o, cmd_valid_o}, 3'b100);
        @(negedge clk);
        cmd_ready_i = 1'b0;
        chk(done_o == 1'b0, "R8 pulse", done_o, 0);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk(!cmd_valid_o && !busy_o, "R9 no restart", {cmd_valid_o, busy_o}, 0);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni      = 1'b0;
    start_i     = 1'b0;
    vector_i    = 8'h00;
    cmd_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !cmd_valid_o, "R1 in reset", {busy_o, done_o, cmd_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !cmd_valid_o, "R1 after reset",
        {busy_o, done_o, cmd_valid_o}, 0);
    // directed corners
    run_seq(8'h08, 0, 1'b1, 1'b0);
    run_seq(8'hFF, 3, 1'b0, 1'b1);
    run_seq(8'h00, 6, 1'b0, 1'b0);
    // random mix
    for (int s = 0; s < 10; s++)
      run_seq(8'($urandom), $urandom_range(5, 0), 1'($urandom), 1'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule